// File: doc/BRIEF.md
# Shared-Bus Lock Arbiter with Atomic Swap

This block is the front end between several processors and a small shared memory holding lock words. Each processor owns a spin-lock engine. The engines compete for a single bus, and a round-robin arbiter grants that bus to one engine per tenure.

The memory side performs three bus operations: plain read, plain write and atomic swap. A swap fetches the addressed word and stores the locked value in the same word. It does this in one two-cycle tenure that the arbiter will not split.

To acquire a lock, an engine polls the word with plain reads. It attempts a swap only after one of those reads shows the word free. The swap's returned old value tells the engine whether it won. Releasing a lock writes zero back to the word. The bus outputs expose each tenure so that the traffic can be observed.

Top module: `lockbus_top`

## Requirements
- R1: At most one bit of `bus_gnt` is set in any cycle. Requesters that ask in the same cycle are granted one at a time, each after the previous tenure ends.
- R2: A swap tenure is exactly two cycles long.
  - Both cycles carry the same grant bit and `bus_op` = 3.
  - `bus_done` is low in the first cycle and high in the second.
  - No other access occurs between the two cycles.
- R3: A lock word of 0 is free and any other value is held. A swap stores the locked value 1 and returns the previous contents on `bus_rdata` in its done cycle.
- R4: After `acq_go[i]`, engine i issues only plain reads (`bus_op` = 1). It starts a swap only after its most recent read returned 0.
- R5: A swap that returns a nonzero old value leaves the engine without ownership. The engine then resumes plain reads.
- R6: Grants rotate round-robin. While several engines request continuously, consecutive tenures go to different engines, in rising index order with wraparound.
- R7: Asserting `rel_go[i]` while `owned[i]` is high makes engine i issue a write (`bus_op` = 2) of 0 to its lock word. `owned[i]` falls after that write completes.
- R8: Among engines that use the same lock address, at most one has `owned` high at any time.
- R9: After reset there are no grants, `bus_op` is 0, no engine owns a lock, and every lock word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_go | input | NPROC | One-cycle pulse per engine that starts an acquire; ignored unless that engine is idle |
| rel_go | input | NPROC | One-cycle pulse per engine that starts a release; ignored unless that engine owns its lock |
| lock_addr | input | NPROC*ADDR_W | Lock address for engine i in slice [i*ADDR_W +: ADDR_W], captured at `acq_go` |
| owned | output | NPROC | Engine i holds its lock |
| bus_gnt | output | NPROC | One-hot grant of the current tenure |
| bus_op | output | 2 | Current operation: 0 idle, 1 read, 2 write, 3 swap |
| bus_addr | output | ADDR_W | Word address of the current operation |
| bus_done | output | 1 | Last cycle of the current tenure |
| bus_rdata | output | DATA_W | Read value, or swap old value, in the done cycle |

## Verification
The bench targets a set of corner cases, each paired with the failure a wrong design would show:
- **Two engines racing for one free lock.** Both read 0, so the loser's swap must see 1. A swap that could be split, or one that skipped the old-value test, would leave two engines reporting ownership.
- **Engines spinning on a held lock.** They must never swap. A design that swapped blindly would show swap tenures returning 1.
- **Grant order while engines spin.** Tenures must alternate between the spinning engines. A fixed-priority arbiter would keep repeating the same engine.
- **Release.** It must appear on the bus as a write, and it must hand the lock to a waiter. A release that dropped ownership without writing 0 would leave waiters spinning forever.

// File: rtl/lockbus_pkg.sv
package lockbus_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SWAP  = 2'd3
    } bus_op_e;

    typedef struct packed {
        logic              vld;
        bus_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_POLL,
        E_SWAP,
        E_OWN,
        E_FREE
    } eng_state_e;

    function automatic logic word_free(input logic [DATA_W-1:0] w);
        return w == '0;
    endfunction

endpackage

// File: rtl/lockbus_arb.sv
module lockbus_arb #(
    parameter int NPROC = 3,
    localparam int IDXW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPROC-1:0] req,
    input  logic             done,
    output logic [NPROC-1:0] gnt,
    output logic [IDXW-1:0]  gnt_idx,
    output logic             gnt_vld
);
    logic [IDXW-1:0] ptr_q;
    logic [IDXW-1:0] hold_idx_q;
    logic            hold_q;
    logic [IDXW-1:0] pick;
    logic            any;

    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int k = NPROC - 1; k >= 0; k--) begin
            logic [IDXW-1:0] cand;
            cand = IDXW'((int'(ptr_q) + k) % NPROC);
            if (req[cand]) begin
                pick = cand;
                any  = 1'b1;
            end
        end
    end

    always_comb begin
        gnt_vld = hold_q || any;
        gnt_idx = hold_q ? hold_idx_q : pick;
        gnt     = '0;
        if (gnt_vld) gnt[gnt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else if (gnt_vld) begin
            if (done) begin
                hold_q <= 1'b0;
                ptr_q  <= (gnt_idx == IDXW'(NPROC - 1)) ? '0 : gnt_idx + 1'b1;
            end else begin
                hold_q     <= 1'b1;
                hold_idx_q <= gnt_idx;
            end
        end
    end
endmodule

// File: rtl/lockbus_mem.sv
module lockbus_mem
    import lockbus_pkg::*;
#(
    parameter logic [DATA_W-1:0] LOCK_VAL = 8'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] old_q;
    logic              swap_pend_q;

    always_comb begin
        done  = 1'b0;
        rdata = '0;
        if (req.vld) begin
            unique case (req.op)
                OP_READ:  begin done = 1'b1; rdata = mem_q[req.addr]; end
                OP_WRITE: done = 1'b1;
                OP_SWAP:  if (swap_pend_q) begin done = 1'b1; rdata = old_q; end
                default:  done = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            old_q       <= '0;
            swap_pend_q <= 1'b0;
        end else if (req.vld) begin
            if (req.op == OP_WRITE) begin
                mem_q[req.addr] <= req.wdata;
            end else if (req.op == OP_SWAP) begin
                if (swap_pend_q) begin
                    mem_q[req.addr] <= LOCK_VAL;
                    swap_pend_q     <= 1'b0;
                end else begin
                    old_q       <= mem_q[req.addr];
                    swap_pend_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lockbus_engine.sv
module lockbus_engine
    import lockbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_go,
    input  logic              rel_go,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              gnt,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output bus_req_t          req,
    output logic              owned
);
    eng_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fin;

    assign fin   = gnt && done;
    assign owned = (st_q == E_OWN) || (st_q == E_FREE);

    always_comb begin
        req.vld   = (st_q == E_POLL) || (st_q == E_SWAP) || (st_q == E_FREE);
        req.addr  = addr_q;
        req.wdata = '0;
        unique case (st_q)
            E_POLL:  req.op = OP_READ;
            E_SWAP:  req.op = OP_SWAP;
            E_FREE:  req.op = OP_WRITE;
            default: req.op = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= E_IDLE;
            addr_q <= '0;
        end else begin
            unique case (st_q)
                E_IDLE: if (acq_go) begin
                    st_q   <= E_POLL;
                    addr_q <= addr_in;
                end
                E_POLL: if (fin && word_free(rdata)) st_q <= E_SWAP;
                E_SWAP: if (fin) st_q <= word_free(rdata) ? E_OWN : E_POLL;
                E_OWN:  if (rel_go) st_q <= E_FREE;
                E_FREE: if (fin) st_q <= E_IDLE;
                default: st_q <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lockbus_top.sv
module lockbus_top
    import lockbus_pkg::*;
#(
    parameter int                NPROC    = 3,
    parameter logic [DATA_W-1:0] LOCK_VAL = 8'd1,
    localparam int               IDXW     = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPROC-1:0]        acq_go,
    input  logic [NPROC-1:0]        rel_go,
    input  logic [NPROC*ADDR_W-1:0] lock_addr,
    output logic [NPROC-1:0]        owned,
    output logic [NPROC-1:0]        bus_gnt,
    output logic [1:0]              bus_op,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    bus_done,
    output logic [DATA_W-1:0]       bus_rdata
);
    bus_req_t          reqs [NPROC];
    logic [NPROC-1:0]  req_vec;
    logic [IDXW-1:0]   gnt_idx;
    logic              gnt_vld;
    bus_req_t          mem_req;

    for (genvar g = 0; g < NPROC; g++) begin : g_eng
        lockbus_engine eng_i (
            .clk     (clk),
            .rst     (rst),
            .acq_go  (acq_go[g]),
            .rel_go  (rel_go[g]),
            .addr_in (lock_addr[g*ADDR_W +: ADDR_W]),
            .gnt     (bus_gnt[g]),
            .done    (bus_done),
            .rdata   (bus_rdata),
            .req     (reqs[g]),
            .owned   (owned[g])
        );
        assign req_vec[g] = reqs[g].vld;
    end

    lockbus_arb #(.NPROC(NPROC)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req_vec),
        .done    (bus_done),
        .gnt     (bus_gnt),
        .gnt_idx (gnt_idx),
        .gnt_vld (gnt_vld)
    );

    always_comb begin
        mem_req     = reqs[gnt_idx];
        mem_req.vld = gnt_vld && reqs[gnt_idx].vld;
    end

    lockbus_mem #(.LOCK_VAL(LOCK_VAL)) mem_i (
        .clk   (clk),
        .rst   (rst),
        .req   (mem_req),
        .done  (bus_done),
        .rdata (bus_rdata)
    );

    assign bus_op   = mem_req.vld ? mem_req.op : OP_IDLE;
    assign bus_addr = mem_req.addr;
endmodule

// File: rtl/lockbus_chk.sv
module lockbus_chk
    import lockbus_pkg::*;
#(
    parameter int NPROC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NPROC-1:0]  owned,
    input logic [NPROC-1:0]  bus_gnt,
    input logic [1:0]        bus_op,
    input logic              bus_done,
    input logic [DATA_W-1:0] bus_rdata
);
    a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_gnt));

    a_r2_swap_unsplit: assert property (@(posedge clk) disable iff (rst)
        (|bus_gnt && bus_op == OP_SWAP && !bus_done)
        |=> ($stable(bus_gnt) && bus_op == OP_SWAP && bus_done));

    for (genvar i = 0; i < NPROC; i++) begin : g_per
        logic seen_free_q;
        always_ff @(posedge clk) begin
            if (rst) seen_free_q <= 1'b0;
            else if (bus_done && bus_gnt[i]) begin
                if (bus_op == OP_READ)      seen_free_q <= (bus_rdata == '0);
                else if (bus_op == OP_SWAP) seen_free_q <= 1'b0;
            end
        end

        a_r4_swap_after_free: assert property (@(posedge clk) disable iff (rst)
            (bus_gnt[i] && bus_op == OP_SWAP && !bus_done) |-> seen_free_q);

        a_r5_own_needs_won_swap: assert property (@(posedge clk) disable iff (rst)
            $rose(owned[i]) |->
            $past(bus_done && bus_gnt[i] && bus_op == OP_SWAP && bus_rdata == '0));

        a_r7_drop_after_write: assert property (@(posedge clk) disable iff (rst)
            $fell(owned[i]) |-> $past(bus_done && bus_gnt[i] && bus_op == OP_WRITE));
    end
endmodule

bind lockbus_top lockbus_chk #(.NPROC(NPROC)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .owned     (owned),
    .bus_gnt   (bus_gnt),
    .bus_op    (bus_op),
    .bus_done  (bus_done),
    .bus_rdata (bus_rdata)
);

// File: tb/lockbus_tb_top.sv
module lockbus_tb_top;
    import lockbus_pkg::*;

    localparam int N = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        acq_go = '0;
    logic [N-1:0]        rel_go = '0;
    logic [N*ADDR_W-1:0] lock_addr = '0;
    logic [N-1:0]        owned;
    logic [N-1:0]        bus_gnt;
    logic [1:0]          bus_op;
    logic [ADDR_W-1:0]   bus_addr;
    logic                bus_done;
    logic [DATA_W-1:0]   bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    int tw [256];
    int to [256];
    int tr [256];
    int tn = 0;
    int mx_bad = 0;
    int sw_bad = 0;
    int prev_swap_first = -1;

    always #10 clk = ~clk;

    lockbus_top #(.NPROC(N)) dut_i (
        .clk(clk), .rst(rst), .acq_go(acq_go), .rel_go(rel_go),
        .lock_addr(lock_addr), .owned(owned), .bus_gnt(bus_gnt),
        .bus_op(bus_op), .bus_addr(bus_addr), .bus_done(bus_done),
        .bus_rdata(bus_rdata)
    );

    function automatic int who(input logic [N-1:0] g);
        int w = -1;
        for (int i = 0; i < N; i++) if (g[i]) w = i;
        return w;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_swap_first >= 0) begin
                if (!(who(bus_gnt) == prev_swap_first && bus_op == 2'd3 && bus_done))
                    sw_bad++;
            end
            prev_swap_first = (bus_op == 2'd3 && !bus_done && bus_gnt != '0) ? who(bus_gnt) : -1;
            if ($countones(bus_gnt) > 1) mx_bad++;
            for (int i = 0; i < N; i++)
                for (int j = i + 1; j < N; j++)
                    if (owned[i] && owned[j] &&
                        lock_addr[i*ADDR_W +: ADDR_W] == lock_addr[j*ADDR_W +: ADDR_W])
                        mx_bad++;
            if (bus_done && tn < 256) begin
                tw[tn] = who(bus_gnt);
                to[tn] = int'(bus_op);
                tr[tn] = int'(bus_rdata);
                tn++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_acq(input logic [N-1:0] m, input logic [ADDR_W-1:0] a);
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) if (m[i]) lock_addr[i*ADDR_W +: ADDR_W] = a;
        acq_go = m;
        @(posedge clk); #1;
        acq_go = '0;
    endtask

    task automatic pulse_rel(input logic [N-1:0] m);
        @(posedge clk); #1;
        rel_go = m;
        @(posedge clk); #1;
        rel_go = '0;
    endtask

    task automatic wait_owned(input logic [N-1:0] m, input int lim);
        for (int c = 0; c < lim && (owned & m) == '0; c++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(owned == '0, "R9 owned after reset", int'(owned), 0);
        check(bus_gnt == '0 && bus_op == 2'd0, "R9 bus idle after reset", int'(bus_op), 0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic t_uncontended();
        tn = 0;
        pulse_acq(3'b001, 3'd2);
        wait_owned(3'b001, 30);
        check(owned[0], "R3 free lock acquired", int'(owned[0]), 1);
        check(tw[0] == 0 && to[0] == 1, "R4 first op is read", to[0], 1);
        check(tr[0] == 0, "R9 fresh lock word reads 0", tr[0], 0);
        check(tw[1] == 0 && to[1] == 3 && tr[1] == 0, "R2 swap returns old 0", tr[1], 0);
        check(tn == 2, "R4 only read then swap", tn, 2);
    endtask

    task automatic t_spin_held();
        int swaps = 0;
        tn = 0;
        pulse_acq(3'b010, 3'd2);
        repeat (20) @(negedge clk);
        for (int k = 0; k < tn; k++) begin
            if (to[k] == 3) swaps++;
            if (tw[k] == 1 && to[k] == 1 && tr[k] != 1) swaps += 100;
        end
        check(owned[1] == 1'b0, "R3 held lock not acquired", int'(owned[1]), 0);
        check(swaps == 0, "R4 no swap on held lock", swaps, 0);
        check(tn >= 5, "R4 engine keeps polling", tn, 5);
    endtask

    task automatic t_round_robin();
        int rep = 0;
        int seen2 = 0;
        pulse_acq(3'b100, 3'd2);
        tn = 0;
        repeat (16) @(negedge clk);
        for (int k = 1; k < tn; k++) begin
            if (tw[k] == tw[k-1]) rep++;
            if (tw[k] == 2) seen2++;
        end
        check(rep == 0, "R6 grants alternate", rep, 0);
        check(seen2 > 0 && tn >= 8, "R6 both spinners served", seen2, 4);
    endtask

    task automatic t_release();
        int wr = 0;
        tn = 0;
        pulse_rel(3'b001);
        wait_owned(3'b110, 40);
        for (int k = 0; k < tn; k++) if (tw[k] == 0 && to[k] == 2) wr++;
        check(owned[0] == 1'b0, "R7 releaser drops ownership", int'(owned[0]), 0);
        check(wr == 1, "R7 release is one write", wr, 1);
        check($countones(owned[2:1]) == 1, "R8 exactly one waiter wins", $countones(owned[2:1]), 1);
        pulse_rel(owned[1] ? 3'b010 : 3'b100);
        wait_owned(owned[1] ? 3'b100 : 3'b010, 40);
        check($countones(owned) == 1, "R7 lock handed to last waiter", $countones(owned), 1);
        pulse_rel(owned);
        repeat (6) @(negedge clk);
        check(owned == '0, "R7 all released", int'(owned), 0);
    endtask

    task automatic t_race();
        int w;
        int l;
        int fail_sw = -1;
        int later_rd = 0;
        tn = 0;
        pulse_acq(3'b101, 3'd5);
        wait_owned(3'b101, 40);
        repeat (8) @(negedge clk);
        check($countones(owned) == 1, "R8 one owner in race", $countones(owned), 1);
        w = owned[0] ? 0 : 2;
        l = (w == 0) ? 2 : 0;
        for (int k = 0; k < tn; k++) begin
            if (tw[k] == l && to[k] == 3 && tr[k] == 1 && fail_sw < 0) fail_sw = k;
            if (fail_sw >= 0 && k > fail_sw && tw[k] == l && to[k] == 1) later_rd++;
        end
        check(fail_sw >= 0, "R5 loser swap sees held", fail_sw, 1);
        check(later_rd > 0 && !owned[l], "R5 loser resumes polling", later_rd, 1);
        check(mx_bad == 0, "R8 R1 monitor clean", mx_bad, 0);
        check(sw_bad == 0, "R2 swaps never split", sw_bad, 0);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_uncontended();
        t_spin_held();
        t_round_robin();
        t_release();
        t_race();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule